// File: doc/BRIEF.md
# Four-Function Look-Ahead ALU

This block is a purely combinational arithmetic logic unit for a small datapath. It takes two operands of `WIDTH` bits (8 by default) and produces one result of the same width. Four separate select strobes choose the function: addition, subtraction, logical shift left and arithmetic shift right. A fifth request, for incrementing, reuses the adder to add one to operand A. This lets the surrounding control logic step a program counter without a second adder.

Addition, subtraction and increment all run through a single carry look-ahead adder. The adder forms each carry from per-bit generate and propagate terms instead of passing it along a chain. Subtraction feeds the inverted B operand into the adder and forces the carry into bit 0 high, which gives the two's complement difference. An output multiplexer steers the winning function's value onto the result lines. A carry-out flag and a zero flag come out next to the result. Registers, timing and operand routing stay in the enclosing datapath, so every pin is a plain level signal with no handshake.

Top module: `quad_alu`

## Requirements
- R1: With `sel_add` winning, `result` equals (A + B) mod 256 and `carry_out` equals bit 8 of the 9-bit sum.
- R2: With `sel_sub` winning, `result` equals (A - B) mod 256, formed as A + ~B + 1, and `carry_out` is 1 exactly when A >= B (no borrow).
- R3: With `sel_shl` winning, `result` is A shifted one place toward the MSB, bit 0 is 0 and the old bit 7 is dropped.
- R4: With `sel_shr` winning, `result` is A shifted one place toward the LSB, bit 7 keeps the old bit 7 and the old bit 0 is dropped.
- R5: When several selects are high, the winner is the first of the order add, subtract, shift left, shift right, and `inc_req` ranks below all four.
- R6: With no select and no `inc_req` high, `result` is 0 and `carry_out` is 0, whatever the operands are.
- R7: With `inc_req` winning, `result` equals (A + 1) mod 256, B has no effect, and `carry_out` is 1 only when A is 255.
- R8: `zero` is 1 exactly when `result` is 0, in every mode.
- R9: When a shift wins, `carry_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand; also the shift source and the value to increment |
| op_b | input | WIDTH | Second operand for add and subtract |
| sel_add | input | 1 | Add strobe, highest priority |
| sel_sub | input | 1 | Subtract strobe |
| sel_shl | input | 1 | Logical shift-left strobe |
| sel_shr | input | 1 | Arithmetic shift-right strobe |
| inc_req | input | 1 | Increment request, lowest priority |
| result | output | WIDTH | Value of the winning function |
| carry_out | output | 1 | Carry out of the top bit for adder functions, else 0 |
| zero | output | 1 | High when result is 0 |

## Verification
The checker evaluates its properties whenever the combinational outputs settle. It takes for granted that every input is a known 0 or 1, and it skips evaluation while any input is unknown. The bench meets this by driving every operand and strobe together in one step, a short time after a clock edge. It then samples only at the following falling edge, so the properties and the comparisons always see settled, fully defined inputs. Strobe combinations cover none, each single select, overlapping selects and the increment request on its own.

// File: rtl/quad_alu_pkg.sv
package quad_alu_pkg;
  typedef enum logic [2:0] {
    FN_NONE = 3'd0,
    FN_ADD  = 3'd1,
    FN_SUB  = 3'd2,
    FN_SHL  = 3'd3,
    FN_SHR  = 3'd4,
    FN_INC  = 3'd5
  } alu_fn_e;
endpackage

// File: rtl/quad_alu_decode.sv
// Priority decode of the strobes: add > sub > shl > shr > increment (R5).
module quad_alu_decode
  import quad_alu_pkg::*;
(
  input  logic    sel_add,
  input  logic    sel_sub,
  input  logic    sel_shl,
  input  logic    sel_shr,
  input  logic    inc_req,
  output alu_fn_e fn
);
  always_comb begin
    if (sel_add)      fn = FN_ADD;
    else if (sel_sub) fn = FN_SUB;
    else if (sel_shl) fn = FN_SHL;
    else if (sel_shr) fn = FN_SHR;
    else if (inc_req) fn = FN_INC;
    else              fn = FN_NONE;
  end
endmodule

// File: rtl/quad_alu_cla.sv
// Carry look-ahead adder: every carry is a flat sum of products of
// generate/propagate terms and the carry-in.
module quad_alu_cla #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;
  logic [WIDTH:0]   carry;

  assign gen      = x & y;
  assign prop     = x ^ y;
  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_carry
    always_comb begin
      logic acc;
      logic term;
      acc  = 1'b0;
      for (int j = 0; j <= i; j++) begin
        term = gen[j];
        for (int k = j + 1; k <= i; k++) term = term & prop[k];
        acc = acc | term;
      end
      term = cin;
      for (int k = 0; k <= i; k++) term = term & prop[k];
      carry[i+1] = acc | term;
    end
  end

  assign sum  = prop ^ carry[WIDTH-1:0];
  assign cout = carry[WIDTH];
endmodule

// File: rtl/quad_alu_shift.sv
// One-place shifts: logical toward MSB, arithmetic toward LSB.
module quad_alu_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] up,
  output logic [WIDTH-1:0] down
);
  assign up   = {src[WIDTH-2:0], 1'b0};
  assign down = {src[WIDTH-1], src[WIDTH-1:1]};
endmodule

// File: rtl/quad_alu.sv
module quad_alu
  import quad_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sel_add,
  input  logic             sel_sub,
  input  logic             sel_shl,
  input  logic             sel_shr,
  input  logic             inc_req,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             zero
);
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  alu_fn_e          fn;
  logic [WIDTH-1:0] addend;
  logic             carry_in;
  logic [WIDTH-1:0] sum;
  logic             sum_cout;
  logic [WIDTH-1:0] sh_up;
  logic [WIDTH-1:0] sh_down;

  quad_alu_decode u_decode (
    .sel_add (sel_add),
    .sel_sub (sel_sub),
    .sel_shl (sel_shl),
    .sel_shr (sel_shr),
    .inc_req (inc_req),
    .fn      (fn)
  );

  // Adder operand steering: subtract inverts B, increment zeroes it;
  // both force the bit-0 carry high.
  always_comb begin
    unique case (fn)
      FN_SUB:  addend = ~op_b;
      FN_INC:  addend = ALL_ZERO;
      default: addend = op_b;
    endcase
    carry_in = (fn == FN_SUB) || (fn == FN_INC);
  end

  quad_alu_cla #(.WIDTH(WIDTH)) u_cla (
    .x    (op_a),
    .y    (addend),
    .cin  (carry_in),
    .sum  (sum),
    .cout (sum_cout)
  );

  quad_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .src  (op_a),
    .up   (sh_up),
    .down (sh_down)
  );

  // Output multiplexer
  always_comb begin
    result    = ALL_ZERO;
    carry_out = 1'b0;
    unique case (fn)
      FN_ADD, FN_SUB, FN_INC: begin
        result    = sum;
        carry_out = sum_cout;
      end
      FN_SHL:  result = sh_up;
      FN_SHR:  result = sh_down;
      default: result = ALL_ZERO;
    endcase
  end

  assign zero = (result == ALL_ZERO);
endmodule

// File: rtl/quad_alu_checker.sv
module quad_alu_checker #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             sel_add,
  input logic             sel_sub,
  input logic             sel_shl,
  input logic             sel_shr,
  input logic             inc_req,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             zero
);
  logic known;
  assign known = !$isunknown({op_a, op_b, sel_add, sel_sub, sel_shl, sel_shr, inc_req});

  always_comb begin
    if (known) begin
      // R8
      p_zero_tracks_result_r8: assert (zero == (result == '0))
        else $error("zero flag disagrees with result");
      // R6
      if (!sel_add && !sel_sub && !sel_shl && !sel_shr && !inc_req) begin
        p_idle_clear_r6: assert (result == '0 && !carry_out)
          else $error("idle output not cleared");
      end
      // R3 and R9
      if (!sel_add && !sel_sub && sel_shl) begin
        p_shl_fill_r3: assert (!result[0] && result[WIDTH-1:1] == op_a[WIDTH-2:0])
          else $error("shift left wrong");
        p_shl_no_carry_r9: assert (!carry_out)
          else $error("carry during shift left");
      end
      // R4 and R9
      if (!sel_add && !sel_sub && !sel_shl && sel_shr) begin
        p_shr_sign_r4: assert (result[WIDTH-1] == op_a[WIDTH-1] &&
                               result[WIDTH-2:0] == op_a[WIDTH-1:1])
          else $error("shift right wrong");
        p_shr_no_carry_r9: assert (!carry_out)
          else $error("carry during shift right");
      end
      // R7
      if (!sel_add && !sel_sub && !sel_shl && !sel_shr && inc_req) begin
        p_inc_wrap_r7: assert (carry_out == (op_a == '1))
          else $error("increment carry wrong");
      end
    end
  end
endmodule

bind quad_alu quad_alu_checker #(.WIDTH(WIDTH)) u_checker (
  .op_a      (op_a),
  .op_b      (op_b),
  .sel_add   (sel_add),
  .sel_sub   (sel_sub),
  .sel_shl   (sel_shl),
  .sel_shr   (sel_shr),
  .inc_req   (inc_req),
  .result    (result),
  .carry_out (carry_out),
  .zero      (zero)
);

// File: tb/quad_alu_test.sv
module quad_alu_test;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] res;
    logic         cy;
    logic         zf;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         sel_add = 1'b0, sel_sub = 1'b0, sel_shl = 1'b0, sel_shr = 1'b0, inc_req = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;
  logic         zero;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;
  exp_t sb_q[$];

  always #10 clk = ~clk;  // 50 MHz

  quad_alu #(.WIDTH(W)) uut (
    .op_a      (op_a),
    .op_b      (op_b),
    .sel_add   (sel_add),
    .sel_sub   (sel_sub),
    .sel_shl   (sel_shl),
    .sel_shr   (sel_shr),
    .inc_req   (inc_req),
    .result    (result),
    .carry_out (carry_out),
    .zero      (zero)
  );

  // Driver: applies one vector per cycle and queues the model's answer.
  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [3:0] sels, input logic inc, input string tag);
    exp_t e;
    int   wide;
    @(posedge clk);
    #1;
    op_a = a; op_b = b;
    {sel_shr, sel_shl, sel_sub, sel_add} = sels;
    inc_req = inc;
    wide = 0;
    e.cy = 1'b0;
    if (sels[0]) begin
      wide = int'(a) + int'(b);
      e.res = W'(wide); e.cy = wide > 255;
    end else if (sels[1]) begin
      wide = int'(a) - int'(b);
      e.res = W'(wide); e.cy = (a >= b);
    end else if (sels[2]) begin
      e.res = W'(int'(a) * 2);
    end else if (sels[3]) begin
      e.res = W'((int'(a) / 2) + (a[W-1] ? 128 : 0));
    end else if (inc) begin
      wide = int'(a) + 1;
      e.res = W'(wide); e.cy = (a == 8'hFF);
    end else begin
      e.res = '0;
    end
    e.zf  = (e.res == 0);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares at the falling edge, away from input changes.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (result !== e.res || carry_out !== e.cy || zero !== e.zf) begin
        n_fail++;
        $display("FAIL %s: got res=%h cy=%b z=%b, expected res=%h cy=%b z=%b",
                 e.tag, result, carry_out, zero, e.res, e.cy, e.zf);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] a, b;
    // Idle state and R6 with non-zero operands
    drive(8'h00, 8'h00, 4'b0000, 1'b0, "R6 idle zeros");
    drive(8'hA5, 8'h3C, 4'b0000, 1'b0, "R6 idle ignores operands");
    // R1 add
    drive(8'h12, 8'h34, 4'b0001, 1'b0, "R1 add");
    drive(8'hFF, 8'h01, 4'b0001, 1'b0, "R1 add wrap R8 zero");
    drive(8'hF0, 8'h20, 4'b0001, 1'b0, "R1 add carry");
    drive(8'h55, 8'hAA, 4'b0001, 1'b0, "R1 add all ones");
    // R2 sub
    drive(8'h50, 8'h20, 4'b0010, 1'b0, "R2 sub");
    drive(8'h00, 8'h01, 4'b0010, 1'b0, "R2 sub borrow");
    drive(8'h7F, 8'h7F, 4'b0010, 1'b0, "R2 sub equal R8 zero");
    // R3 / R4 / R9 shifts
    drive(8'h81, 8'hFF, 4'b0100, 1'b0, "R3 shl drops msb R9");
    drive(8'h80, 8'h00, 4'b0100, 1'b0, "R3 shl to zero R8");
    drive(8'h81, 8'h00, 4'b1000, 1'b0, "R4 shr keeps sign R9");
    drive(8'h41, 8'h00, 4'b1000, 1'b0, "R4 shr positive");
    drive(8'h01, 8'h00, 4'b1000, 1'b0, "R4 shr to zero R8");
    // R5 priority
    drive(8'h10, 8'h05, 4'b1111, 1'b1, "R5 add beats all");
    drive(8'h10, 8'h05, 4'b1110, 1'b1, "R5 sub beats shifts");
    drive(8'h90, 8'h05, 4'b1100, 1'b1, "R5 shl beats shr");
    drive(8'h90, 8'h05, 4'b1000, 1'b1, "R5 shr beats inc");
    // R7 increment
    drive(8'h3F, 8'hEE, 4'b0000, 1'b1, "R7 inc ignores B");
    drive(8'hFF, 8'h77, 4'b0000, 1'b1, "R7 inc wrap");
    // Sweep of pseudo-random patterns over every mode
    a = 8'h1D; b = 8'hC3;
    for (int i = 0; i < 300; i++) begin
      a = a * 8'd37 + 8'd11;
      b = b * 8'd73 + 8'd5;
      drive(a, b, 4'(1 << (i % 4)), 1'b0, "R1 R2 R3 R4 sweep");
      drive(a, b, 4'b0000, 1'b1, "R7 sweep");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule